// File: doc/BRIEF.md
# Video Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C, standard open-drain signalling) that answers at a fixed 7-bit device address. It holds a small bank of 16-bit configuration words. Each word is reached through an 8-bit subaddress that the controller sends right after the device address. Data moves high byte first.

To write, the controller sends a subaddress byte and then two data bytes. To read, it first writes a subaddress with nothing after it. It then opens a read transfer, either with a repeated START or with STOP followed by START. That read transfer returns the high byte and then the low byte.

Selected bits of the stored words are decoded continuously onto parallel outputs. These outputs steer a video front end:
- a colour-matrix select between component and RGB,
- a choice between two ADCs as the sync source,
- a 4-bit input selector for one ADC,
- several offset and mixing fields.

The bus pins are sampled through synchronisers on the system clock. The target pulls SDA low only through an output-enable, and it never stretches the clock.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, subaddress 0x4B holds 0x8100, and subaddresses 0x49 and 0x3F hold 0x0000. The decoded outputs then read fb_offset=32, matrix_rgb=1, softmix_fixed=0, rb_offset=0, sync_adc6=0 and vin_sel=0, and sda_oe is low.
- R2: The target acknowledges an address byte only when its upper seven bits equal 0x58 (0xB0 for write, 0xB1 for read). It acknowledges by driving SDA low during the ninth clock. Any other address gets no acknowledge, and the target stays silent until the next START.
- R3: A write transfer consists of a subaddress byte, a high data byte and a low data byte, each acknowledged. When the low byte completes, the addressed word becomes {high, low}. Any further bytes in the same transfer are acknowledged and discarded.
- R4: A read transfer returns the word at the last written subaddress, high byte first, MSB first within each byte. The word is exactly the last value written, or the reset value if nothing was written.
- R5: Word 0x4B is decoded as follows: bits 15:10 drive fb_offset, bit 8 drives matrix_rgb (0 = YCrCb, 1 = RGB), bit 7 drives softmix_fixed, and bits 2:0 drive rb_offset.
- R6: Bit 3 of word 0x49 drives sync_adc6. A value of 0 selects the first ADC (ADC4) and 1 selects the second (ADC6).
- R7: Bits 3:0 of word 0x3F drive vin_sel. 0000 means off, and 0001 to 0111 route inputs 1 to 7.
- R8: A write to a subaddress other than 0x3F, 0x49 or 0x4B is acknowledged in full and changes nothing. A read of such a subaddress returns 0x0000.
- R9: A STOP or repeated START before the low data byte completes leaves every word unchanged. The subaddress byte alone still moves the read pointer.
- R10: SDA is driven only through sda_oe. sda_oe changes only while SCL is low, and it is released by every START and STOP.
- R11: During a read, a controller acknowledge after the low byte makes the target send the high byte again. A controller no-acknowledge makes the target release SDA for the rest of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| fb_offset | output | 6 | Fast-blank offset field of word 0x4B |
| matrix_rgb | output | 1 | Colour-matrix select, 1 = RGB |
| softmix_fixed | output | 1 | Softmix mode field of word 0x4B |
| rb_offset | output | 3 | R/B offset field of word 0x4B |
| sync_adc6 | output | 1 | Sync-source ADC select, 1 = second ADC |
| vin_sel | output | 4 | Input routed to the second ADC, 0 = off |

## Verification
The bench sweeps all 128 device addresses to confirm that only 0x58 is acknowledged; a loose comparison would acknowledge neighbouring addresses, or all of them. It reads back every one of the 256 subaddresses against a model: a partial decoder would alias unimplemented subaddresses onto real words, and a swapped byte order would show as exchanged halves. It cuts writes short after the subaddress and after the high byte, with both STOP and repeated START; a design that commits on the high byte would corrupt the selects. It also extends reads past the low byte and ends them with a no-acknowledge. A target that kept driving after the no-acknowledge, or that moved SDA while SCL was high, would collide with the controller or create false START and STOP conditions.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NREG   = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // Implemented subaddresses and their bank slots
    localparam byte_t SUB_MIX  = 8'h4B;
    localparam byte_t SUB_SYNC = 8'h49;
    localparam byte_t SUB_VIN  = 8'h3F;
    localparam int IDX_MIX  = 0;
    localparam int IDX_SYNC = 1;
    localparam int IDX_VIN  = 2;

    // Field positions inside the words
    localparam int FBO_LSB = 10;
    localparam int FBO_W   = 6;
    localparam int MTX_BIT = 8;
    localparam int SMX_BIT = 7;
    localparam int RBO_W   = 3;
    localparam int ADC_BIT = 3;
    localparam int VIN_W   = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_HI,
        PH_LO,
        PH_DROP,
        PH_READ,
        PH_WAIT
    } phase_t;

    typedef struct packed {
        logic [FBO_W-1:0] fb_offset;
        logic             matrix_rgb;
        logic             softmix_fixed;
        logic [RBO_W-1:0] rb_offset;
        logic             sync_adc6;
        logic [VIN_W-1:0] vin_sel;
    } cfg_fields_t;

    function automatic byte_t sub_of(input int idx);
        case (idx)
            IDX_MIX:  return SUB_MIX;
            IDX_SYNC: return SUB_SYNC;
            default:  return SUB_VIN;
        endcase
    endfunction

    function automatic word_t reset_of(input int idx);
        case (idx)
            IDX_MIX: return 16'h8100;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/cfgi2c_line_cond.sv
module cfgi2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_p;
    logic                   sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_sh[SYNC_STAGES-1];
            sda_p  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[SYNC_STAGES-1];
    assign sda_lvl   = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_p;
    assign scl_fall  = ~scl_lvl & scl_p;
    assign start_evt = scl_lvl & scl_p & sda_p & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/cfgi2c_engine.sv
module cfgi2c_engine
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h58
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sda_lvl,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  start_evt,
    input  logic  stop_evt,
    input  word_t rd_data,
    output byte_t sub_ptr,
    output logic  wr_en,
    output word_t wr_data,
    output logic  sda_oe
);
    localparam logic [3:0] LAST = 4'(BYTE_W);
    localparam logic [3:0] ACKEND = LAST + 4'd1;

    phase_t     phase, phase_nxt;
    logic [3:0] rcnt;
    byte_t      shreg, hi_q, tx;
    word_t      rd_word;
    logic       lo_next;
    logic       active;

    assign active = (phase != PH_IDLE) && (phase != PH_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            phase_nxt <= PH_IDLE;
            rcnt      <= '0;
            shreg     <= '0;
            hi_q      <= '0;
            tx        <= '0;
            rd_word   <= '0;
            lo_next   <= 1'b0;
            sub_ptr   <= '0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            sda_oe    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                phase     <= PH_ADDR;
                phase_nxt <= PH_ADDR;
                rcnt      <= '0;
                sda_oe    <= 1'b0;
            end else if (stop_evt) begin
                phase     <= PH_IDLE;
                phase_nxt <= PH_IDLE;
                rcnt      <= '0;
                sda_oe    <= 1'b0;
            end else if (active && scl_rise) begin
                if (rcnt < LAST) begin
                    shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                end else if (rcnt == LAST && phase == PH_READ) begin
                    if (sda_lvl) begin
                        phase_nxt <= PH_WAIT;
                    end else begin
                        tx        <= lo_next ? rd_word[BYTE_W-1:0] : rd_word[WORD_W-1:BYTE_W];
                        lo_next   <= ~lo_next;
                        phase_nxt <= PH_READ;
                    end
                end
                rcnt <= rcnt + 4'd1;
            end else if (active && scl_fall) begin
                if (rcnt == LAST) begin
                    // a full byte is in shreg: decide the ninth clock
                    case (phase)
                        PH_ADDR: begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe <= 1'b1;
                                if (shreg[0]) begin
                                    rd_word   <= rd_data;
                                    tx        <= rd_data[WORD_W-1:BYTE_W];
                                    lo_next   <= 1'b1;
                                    phase_nxt <= PH_READ;
                                end else begin
                                    phase_nxt <= PH_SUB;
                                end
                            end else begin
                                phase <= PH_WAIT;
                            end
                        end
                        PH_SUB: begin
                            sub_ptr   <= shreg;
                            sda_oe    <= 1'b1;
                            phase_nxt <= PH_HI;
                        end
                        PH_HI: begin
                            hi_q      <= shreg;
                            sda_oe    <= 1'b1;
                            phase_nxt <= PH_LO;
                        end
                        PH_LO: begin
                            wr_en     <= 1'b1;
                            wr_data   <= {hi_q, shreg};
                            sda_oe    <= 1'b1;
                            phase_nxt <= PH_DROP;
                        end
                        PH_DROP: begin
                            sda_oe    <= 1'b1;
                            phase_nxt <= PH_DROP;
                        end
                        default: begin
                            sda_oe <= 1'b0;
                        end
                    endcase
                end else if (rcnt == ACKEND) begin
                    rcnt   <= '0;
                    phase  <= phase_nxt;
                    sda_oe <= (phase_nxt == PH_READ) ? ~tx[BYTE_W-1] : 1'b0;
                end else if (rcnt != 4'd0 && phase == PH_READ) begin
                    tx     <= {tx[BYTE_W-2:0], 1'b0};
                    sda_oe <= ~tx[BYTE_W-2];
                end
            end
        end
    end

endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
    import cfgi2c_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  byte_t                 sub_ptr,
    input  word_t                 wr_data,
    output word_t                 rd_data,
    output logic [NREG-1:0][WORD_W-1:0] regs
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        word_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= reset_of(g);
            end else if (wr_en && sub_ptr == sub_of(g)) begin
                q <= wr_data;
            end
        end
        assign regs[g] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sub_ptr == sub_of(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/cfgi2c_decode.sv
module cfgi2c_decode
    import cfgi2c_pkg::*;
(
    input  logic [NREG-1:0][WORD_W-1:0] regs,
    output cfg_fields_t                 fields
);
    word_t w_mix, w_sync, w_vin;

    assign w_mix  = regs[IDX_MIX];
    assign w_sync = regs[IDX_SYNC];
    assign w_vin  = regs[IDX_VIN];

    always_comb begin
        fields.fb_offset     = w_mix[FBO_LSB +: FBO_W];
        fields.matrix_rgb    = w_mix[MTX_BIT];
        fields.softmix_fixed = w_mix[SMX_BIT];
        fields.rb_offset     = w_mix[RBO_W-1:0];
        fields.sync_adc6     = w_sync[ADC_BIT];
        fields.vin_sel       = w_vin[VIN_W-1:0];
    end

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h58,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [5:0] fb_offset,
    output logic       matrix_rgb,
    output logic       softmix_fixed,
    output logic [2:0] rb_offset,
    output logic       sync_adc6,
    output logic [3:0] vin_sel
);
    logic  scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    byte_t sub_ptr;
    logic  wr_en;
    word_t wr_data, rd_data;
    logic [NREG-1:0][WORD_W-1:0] regs;
    cfg_fields_t fields;

    cfgi2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    cfgi2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .sub_ptr   (sub_ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfgi2c_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sub_ptr (sub_ptr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .regs    (regs)
    );

    cfgi2c_decode u_dec (
        .regs   (regs),
        .fields (fields)
    );

    assign fb_offset     = fields.fb_offset;
    assign matrix_rgb    = fields.matrix_rgb;
    assign softmix_fixed = fields.softmix_fixed;
    assign rb_offset     = fields.rb_offset;
    assign sync_adc6     = fields.sync_adc6;
    assign vin_sel       = fields.vin_sel;

endmodule

// File: rtl/cfgi2c_checker.sv
module cfgi2c_checker (
    input logic        clk,
    input logic        rst,
    input logic        scl_lvl,
    input logic        start_evt,
    input logic        stop_evt,
    input logic        sda_oe,
    input logic [15:0] cfg_vec
);
    // R10: the data line is only moved while the clock line is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl);

    // R10: a START releases the data line
    assert_start_release_R10: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !sda_oe);

    // R10: a STOP releases the data line
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    // R3: decoded outputs only update after a completed byte, i.e. with SCL low
    assert_cfg_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_vec) |-> !scl_lvl);

endmodule

bind cfg_i2c_target cfgi2c_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .cfg_vec   ({fb_offset, matrix_rgb, softmix_fixed, rb_offset, sync_adc6, vin_sel})
);

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;
    localparam int HALF  = 4;
    localparam int LIMIT = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [5:0] fb_offset;
    logic matrix_rgb, softmix_fixed, sync_adc6;
    logic [2:0] rb_offset;
    logic [3:0] vin_sel;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int oe_viol = 0;
    int hi_cnt = 0;
    logic oe_prev = 1'b0;
    bit done = 0;

    logic [15:0] m_mix  = 16'h8100;
    logic [15:0] m_sync = 16'h0000;
    logic [15:0] m_vin  = 16'h0000;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    cfg_i2c_target u_cfg_i2c_target (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .sda_oe        (sda_oe),
        .fb_offset     (fb_offset),
        .matrix_rgb    (matrix_rgb),
        .softmix_fixed (softmix_fixed),
        .rb_offset     (rb_offset),
        .sync_adc6     (sync_adc6),
        .vin_sel       (vin_sel)
    );

    // R10 monitor: sda_oe must not move during a settled SCL high phase
    always @(posedge clk) begin
        cycles <= cycles + 1;
        hi_cnt <= scl_m ? hi_cnt + 1 : 0;
        oe_prev <= sda_oe;
        if (!rst && hi_cnt >= 4 && scl_m && sda_oe !== oe_prev) oe_viol <= oe_viol + 1;
        if (cycles == LIMIT && !done) begin
            done = 1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        wclk(2); sda_m = b; wclk(HALF - 2);
        scl_m = 1'b1; wclk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        wclk(2); sda_m = 1'b1; wclk(HALF - 2);
        scl_m = 1'b1; wclk(HALF - 1);
        b = sda_bus; wclk(1);
        scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        if (!scl_m) begin
            wclk(2); sda_m = 1'b1; wclk(HALF - 2);
            scl_m = 1'b1; wclk(HALF);
        end
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wclk(2); sda_m = 1'b0; wclk(HALF - 2);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b1; wclk(HALF);
    endtask

    task automatic wbyte(input logic [7:0] d, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        acked = !a;
    endtask

    task automatic rbyte(input bit ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!ack);
    endtask

    task automatic write_reg(input logic [7:0] sub, input logic [15:0] v, output bit all_ack);
        bit a0, a1, a2, a3;
        i2c_start();
        wbyte(8'hB0, a0); wbyte(sub, a1); wbyte(v[15:8], a2); wbyte(v[7:0], a3);
        i2c_stop();
        all_ack = a0 & a1 & a2 & a3;
    endtask

    task automatic read_reg(input logic [7:0] sub, output logic [15:0] v, output bit all_ack);
        bit a0, a1, a2;
        logic [7:0] hb, lb;
        i2c_start();
        wbyte(8'hB0, a0); wbyte(sub, a1);
        i2c_start();
        wbyte(8'hB1, a2);
        rbyte(1'b1, hb); rbyte(1'b0, lb);
        i2c_stop();
        v = {hb, lb};
        all_ack = a0 & a1 & a2;
    endtask

    function automatic logic [15:0] model(input logic [7:0] sub);
        case (sub)
            8'h4B:   return m_mix;
            8'h49:   return m_sync;
            8'h3F:   return m_vin;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        chk(fb_offset == m_mix[15:10], {req, " fb_offset"}, fb_offset, m_mix[15:10]);
        chk(matrix_rgb == m_mix[8], {req, " matrix_rgb"}, matrix_rgb, m_mix[8]);
        chk(softmix_fixed == m_mix[7], {req, " softmix_fixed"}, softmix_fixed, m_mix[7]);
        chk(rb_offset == m_mix[2:0], {req, " rb_offset"}, rb_offset, m_mix[2:0]);
        chk(sync_adc6 == m_sync[3], {req, " sync_adc6"}, sync_adc6, m_sync[3]);
        chk(vin_sel == m_vin[3:0], {req, " vin_sel"}, vin_sel, m_vin[3:0]);
    endtask

    initial begin
        bit ok, a;
        logic [15:0] v;
        logic [7:0] b;
        logic [15:0] pats [4] = '{16'hFFFF, 16'h0000, 16'hA5C3, 16'h5A3C};

        wclk(5);
        rst = 1'b0;
        wclk(5);

        // R1: reset state at the ports
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check_outputs("R1");
        chk(matrix_rgb == 1'b1 && fb_offset == 6'd32, "R1 mix decode", {fb_offset, matrix_rgb}, {6'd32, 1'b1});
        read_reg(8'h4B, v, ok); chk(ok && v == 16'h8100, "R1 0x4B", v, 16'h8100);
        read_reg(8'h49, v, ok); chk(ok && v == 16'h0000, "R1 0x49", v, 0);
        read_reg(8'h3F, v, ok); chk(ok && v == 16'h0000, "R1 0x3F", v, 0);

        // R2: sweep every 7-bit address, only 0x58 is acknowledged
        for (int ad = 0; ad < 128; ad++) begin
            i2c_start();
            wbyte({7'(ad), 1'b0}, a);
            i2c_stop();
            chk(a == (ad == 'h58), "R2 address ack", a, ad == 'h58);
        end
        // R2: after a foreign address the target stays silent for later bytes
        i2c_start(); wbyte(8'hA0, a); wbyte(8'h4B, a); i2c_stop();
        chk(a == 1'b0, "R2 silent after mismatch", a, 0);

        // R7, R4: sweep every selector value of 0x3F
        for (int s = 0; s < 16; s++) begin
            write_reg(8'h3F, {8'h4A, 4'h0, 4'(s)}, ok);
            m_vin = {8'h4A, 4'h0, 4'(s)};
            chk(ok, "R3 write acks", ok, 1);
            chk(vin_sel == 4'(s), "R7 vin_sel", vin_sel, s);
            read_reg(8'h3F, v, ok);
            chk(ok && v == m_vin, "R4 readback 0x3F", v, m_vin);
        end

        // R6: sync ADC select
        write_reg(8'h49, 16'hD754, ok); m_sync = 16'hD754;
        chk(sync_adc6 == 1'b0, "R6 sync_adc6 clear", sync_adc6, 0);
        write_reg(8'h49, 16'hD75C, ok); m_sync = 16'hD75C;
        chk(sync_adc6 == 1'b1, "R6 sync_adc6 set", sync_adc6, 1);

        // R5: field decode of 0x4B under several patterns
        foreach (pats[k]) begin
            write_reg(8'h4B, pats[k], ok); m_mix = pats[k];
            check_outputs("R5");
        end
        write_reg(8'h4B, 16'h8108, ok); m_mix = 16'h8108;
        check_outputs("R5");

        // R8: unimplemented subaddress write is acknowledged and discarded
        write_reg(8'h10, 16'h1234, ok);
        chk(ok, "R8 unimplemented acks", ok, 1);
        check_outputs("R8");
        read_reg(8'h10, v, ok);
        chk(v == 16'h0000, "R8 unimplemented read", v, 0);

        // R9: STOP after the high byte leaves 0x3F unchanged
        i2c_start(); wbyte(8'hB0, a); wbyte(8'h3F, a); wbyte(8'hFF, a); i2c_stop();
        chk(vin_sel == m_vin[3:0], "R9 stop after high byte", vin_sel, m_vin[3:0]);
        // R9: repeated START after the high byte, then read the word back
        i2c_start(); wbyte(8'hB0, a); wbyte(8'h3F, a); wbyte(8'h00, a);
        i2c_start(); wbyte(8'hB1, a);
        rbyte(1'b1, b); v[15:8] = b; rbyte(1'b0, b); v[7:0] = b;
        i2c_stop();
        chk(v == m_vin, "R9 rstart after high byte", v, m_vin);
        // R9: subaddress only moves the pointer
        i2c_start(); wbyte(8'hB0, a); wbyte(8'h4B, a); i2c_stop();
        i2c_start(); wbyte(8'hB1, a);
        rbyte(1'b1, b); v[15:8] = b; rbyte(1'b0, b); v[7:0] = b;
        i2c_stop();
        chk(v == m_mix, "R9 pointer from subaddress", v, m_mix);

        // R3: extra bytes after the low byte are acked and discarded
        i2c_start(); wbyte(8'hB0, a); wbyte(8'h3F, a); wbyte(8'h12, a); wbyte(8'h05, a);
        wbyte(8'h99, a);
        chk(a == 1'b1, "R3 extra byte acked", a, 1);
        wbyte(8'h77, a);
        i2c_stop();
        m_vin = 16'h1205;
        chk(vin_sel == 4'h5, "R3 extra bytes discarded", vin_sel, 5);
        read_reg(8'h3F, v, ok);
        chk(v == 16'h1205, "R3 word after extra bytes", v, 16'h1205);

        // R11: ack after the low byte repeats the high byte, NACK releases
        i2c_start(); wbyte(8'hB0, a); wbyte(8'h3F, a);
        i2c_start(); wbyte(8'hB1, a);
        rbyte(1'b1, b); rbyte(1'b1, b);
        rbyte(1'b0, b);
        chk(b == m_vin[15:8], "R11 third byte is high byte", b, m_vin[15:8]);
        rbyte(1'b0, b);
        chk(b == 8'hFF, "R11 released after NACK", b, 8'hFF);
        i2c_stop();

        // R4, R8: read back every subaddress against the model
        for (int s = 0; s < 256; s++) begin
            read_reg(8'(s), v, ok);
            chk(ok && v == model(8'(s)), "R4 sweep readback", v, model(8'(s)));
        end

        // R10: open-drain timing monitor over the whole run
        chk(oe_viol == 0, "R10 sda_oe moved with SCL high", oe_viol, 0);
        chk(sda_oe == 1'b0, "R10 released when idle", sda_oe, 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule